// File: doc/BRIEF.md
# IDE Channel Address Decoder

This block sits in front of the drive register files of a two-channel IDE controller and turns each I/O request into at most one strobe. Every channel has a command block (eight byte registers, with the data port at offset 0) and a control block (four bytes, with the alternate-status/device-control register at offset 2). A mode register, loaded from the low nibble of a programming-interface byte, chooses which addresses are decoded. In compatibility mode the controller answers at fixed port addresses and advertises no interrupt pin. In native mode it answers only at base addresses supplied from outside and advertises interrupt pin 1.

Each request gives an address, a size code, a write flag and write data. One cycle later the decoder raises a single strobe for the command or control block of channel 0 or 1, together with the offset, size, direction and data of the request. A read that no window accepts, or that a window rejects for its offset or size, gets an all-ones filler response sized to the access. A rejected write raises nothing.

Top module: `ide_chan_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, the decoder is in native mode with `irq_pin` = 1, and all strobes and `fill_vld` are 0.
- R2: At each clock edge a programming-interface low nibble of 4'hA selects compatibility mode and 4'hF selects native mode. Any other nibble keeps the current mode. The upper nibble has no effect.
- R3: `irq_pin` is 8'd0 in compatibility mode and 8'd1 in native mode. It follows the mode register with no further delay.
- R4: In compatibility mode channel 0 decodes its command block at 0x1F0–0x1F7 and its control block at 0x3F4–0x3F7 (register at 0x3F6). Channel 1 decodes 0x170–0x177 and 0x374–0x377 (register at 0x376). The native bases are not decoded in this mode.
- R5: In native mode the command block of channel c covers the 8 bytes at `nat_cmd_base` slice c with its low 3 bits ignored. The control block covers the 4 bytes at `nat_ctl_base` slice c with its low 2 bits ignored. The compatibility addresses are not decoded in this mode.
- R6: The control block accepts only a byte access at offset 2. That access gives a `ctl_stb` pulse with `stb_off` = 2. Any other offset or size gives fill on a read and no strobe on a write.
- R7: The command block accepts a byte access at any offset 0–7 and reports that offset on `stb_off`.
- R8: A word (size code 1) or dword (size code 2 or 3) access to the command block is accepted only at offset 0, the data port. At any other offset a read gets fill and a write is dropped.
- R9: A read that is not accepted gives a one-cycle `fill_vld` with `fill_data` equal to 32'h000000FF for a byte, 32'h0000FFFF for a word and 32'hFFFFFFFF for a dword, and no strobe. This includes reads that hit no window.
- R10: A request sampled at a clock edge shows its result after that same edge as a one-cycle pulse. At most one of the four strobes is high. A strobe carries the request's write flag, size code and write data on `stb_wr`, `stb_size` and `stb_wdata`.
- R11: When windows overlap, the first in the order channel 0 command, channel 0 control, channel 1 command, channel 1 control claims the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_if | input | 8 | Programming-interface byte; the low nibble selects the mode |
| nat_cmd_base | input | 32 | Native command-block bases, 16 bits per channel, channel 0 in the low half |
| nat_ctl_base | input | 32 | Native control-block bases, 16 bits per channel, channel 0 in the low half |
| req_valid | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | I/O byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| req_wdata | input | 32 | Write data |
| cmd_stb | output | 2 | Command-block strobe, one bit per channel |
| ctl_stb | output | 2 | Control-block strobe, one bit per channel |
| stb_wr | output | 1 | Direction of the strobed access |
| stb_off | output | 3 | Register offset inside the claimed block |
| stb_size | output | 2 | Size code of the strobed access |
| stb_wdata | output | 32 | Write data of the strobed access |
| fill_vld | output | 1 | Filler read response valid |
| fill_data | output | 32 | All-ones filler sized to the access |
| irq_pin | output | 8 | Advertised interrupt pin number |

## Verification
A wrong mode bit shows on `irq_pin` at the first sample after the edge that loaded it. It also moves every decode window at once, so the next access to either the fixed or the native addresses strobes the wrong block or returns fill in place of a strobe. A broken priority or size filter shows in the very next cycle as two strobes together, a control strobe off offset 2, or a fill value of the wrong width. The bench mixes directed boundary accesses with seeded random requests that are aimed at the window edges, and compares every output against a model built from the requirements.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int DATA_W = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  // All-ones filler sized to the access; codes 2 and 3 are both dword.
  function automatic logic [DATA_W-1:0] ones_for(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: ones_for = DATA_W'(32'h0000_00FF);
      SZ_WORD: ones_for = DATA_W'(32'h0000_FFFF);
      default: ones_for = {DATA_W{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/ide_mode_reg.sv
module ide_mode_reg #(
  parameter logic [3:0] COMPAT_CODE = 4'hA,
  parameter logic [3:0] NATIVE_CODE = 4'hF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] prog_if,
  output logic       compat_q
);
  logic unused_hi;
  assign unused_hi = ^prog_if[7:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      compat_q <= 1'b0;
    end else if (prog_if[3:0] == COMPAT_CODE) begin
      compat_q <= 1'b1;
    end else if (prog_if[3:0] == NATIVE_CODE) begin
      compat_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ide_window_match.sv
module ide_window_match #(
  parameter int ADDR_W = 16,
  parameter int SPAN   = 8,
  localparam int SL    = $clog2(SPAN)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit,
  output logic [SL-1:0]     off
);
  logic unused_base_lo;
  assign unused_base_lo = ^base[SL-1:0];

  assign hit = (addr[ADDR_W-1:SL] == base[ADDR_W-1:SL]);
  assign off = addr[SL-1:0];
endmodule

// File: rtl/ide_access_filter.sv
module ide_access_filter
  import ide_dec_pkg::*;
#(
  parameter int N_CH        = 2,
  parameter int OFF_W       = 3,
  parameter int CTL_W       = 2,
  parameter int CTL_REG_OFF = 2
) (
  input  logic [N_CH-1:0]       cmd_hit,
  input  logic [N_CH*OFF_W-1:0] cmd_off,
  input  logic [N_CH-1:0]       ctl_hit,
  input  logic [N_CH*CTL_W-1:0] ctl_off,
  input  logic [1:0]            size,
  output logic [N_CH-1:0]       sel_cmd,
  output logic [N_CH-1:0]       sel_ctl,
  output logic [OFF_W-1:0]      sel_off,
  output logic                  accept
);
  // Walk from the highest channel down so the lowest channel wins;
  // inside a channel the command block overrides the control block.
  always_comb begin
    sel_cmd = '0;
    sel_ctl = '0;
    sel_off = '0;
    accept  = 1'b0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (ctl_hit[i]) begin
        sel_cmd    = '0;
        sel_ctl    = '0;
        sel_ctl[i] = 1'b1;
        sel_off    = OFF_W'(ctl_off[i*CTL_W +: CTL_W]);
        accept     = (size == SZ_BYTE) &&
                     (ctl_off[i*CTL_W +: CTL_W] == CTL_W'(CTL_REG_OFF));
      end
      if (cmd_hit[i]) begin
        sel_cmd    = '0;
        sel_ctl    = '0;
        sel_cmd[i] = 1'b1;
        sel_off    = cmd_off[i*OFF_W +: OFF_W];
        accept     = (size == SZ_BYTE) || (cmd_off[i*OFF_W +: OFF_W] == '0);
      end
    end
  end
endmodule

// File: rtl/ide_chan_decoder.sv
module ide_chan_decoder
  import ide_dec_pkg::*;
#(
  parameter int N_CH     = 2,
  parameter int ADDR_W   = 16,
  parameter int CMD_SPAN = 8,
  parameter int CTL_SPAN = 4,
  parameter int CTL_REG_OFF = 2,
  parameter logic [N_CH*ADDR_W-1:0] COMPAT_CMD_BASES = {16'h0170, 16'h01F0},
  parameter logic [N_CH*ADDR_W-1:0] COMPAT_CTL_BASES = {16'h0374, 16'h03F4},
  parameter logic [7:0] NATIVE_PIN = 8'd1,
  localparam int OFF_W = $clog2(CMD_SPAN),
  localparam int CTL_W = $clog2(CTL_SPAN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             prog_if,
  input  logic [N_CH*ADDR_W-1:0] nat_cmd_base,
  input  logic [N_CH*ADDR_W-1:0] nat_ctl_base,
  input  logic                   req_valid,
  input  logic                   req_wr,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_size,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic [N_CH-1:0]        cmd_stb,
  output logic [N_CH-1:0]        ctl_stb,
  output logic                   stb_wr,
  output logic [OFF_W-1:0]       stb_off,
  output logic [1:0]             stb_size,
  output logic [DATA_W-1:0]      stb_wdata,
  output logic                   fill_vld,
  output logic [DATA_W-1:0]      fill_data,
  output logic [7:0]             irq_pin
);
  logic                  compat_q;
  logic [N_CH-1:0]       cmd_hit, ctl_hit, sel_cmd, sel_ctl;
  logic [N_CH*OFF_W-1:0] cmd_off;
  logic [N_CH*CTL_W-1:0] ctl_off;
  logic [OFF_W-1:0]      sel_off;
  logic                  accept, claim, reject_rd;

  ide_mode_reg u_mode (
    .clk(clk), .rst(rst), .prog_if(prog_if), .compat_q(compat_q)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [ADDR_W-1:0] cmd_base, ctl_base;
    assign cmd_base = compat_q ? COMPAT_CMD_BASES[c*ADDR_W +: ADDR_W]
                               : nat_cmd_base[c*ADDR_W +: ADDR_W];
    assign ctl_base = compat_q ? COMPAT_CTL_BASES[c*ADDR_W +: ADDR_W]
                               : nat_ctl_base[c*ADDR_W +: ADDR_W];

    ide_window_match #(.ADDR_W(ADDR_W), .SPAN(CMD_SPAN)) u_cmd_win (
      .addr(req_addr), .base(cmd_base),
      .hit(cmd_hit[c]), .off(cmd_off[c*OFF_W +: OFF_W])
    );
    ide_window_match #(.ADDR_W(ADDR_W), .SPAN(CTL_SPAN)) u_ctl_win (
      .addr(req_addr), .base(ctl_base),
      .hit(ctl_hit[c]), .off(ctl_off[c*CTL_W +: CTL_W])
    );
  end

  ide_access_filter #(
    .N_CH(N_CH), .OFF_W(OFF_W), .CTL_W(CTL_W), .CTL_REG_OFF(CTL_REG_OFF)
  ) u_filter (
    .cmd_hit(cmd_hit), .cmd_off(cmd_off),
    .ctl_hit(ctl_hit), .ctl_off(ctl_off),
    .size(req_size),
    .sel_cmd(sel_cmd), .sel_ctl(sel_ctl), .sel_off(sel_off),
    .accept(accept)
  );

  assign claim     = req_valid && accept;
  assign reject_rd = req_valid && !req_wr && !accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_stb   <= '0;
      ctl_stb   <= '0;
      stb_wr    <= 1'b0;
      stb_off   <= '0;
      stb_size  <= '0;
      stb_wdata <= '0;
      fill_vld  <= 1'b0;
      fill_data <= '0;
    end else begin
      cmd_stb   <= claim ? sel_cmd : '0;
      ctl_stb   <= claim ? sel_ctl : '0;
      stb_wr    <= req_wr;
      stb_off   <= sel_off;
      stb_size  <= req_size;
      stb_wdata <= req_wdata;
      fill_vld  <= reject_rd;
      fill_data <= reject_rd ? ones_for(req_size) : '0;
    end
  end

  assign irq_pin = compat_q ? 8'd0 : NATIVE_PIN;
endmodule

// File: rtl/ide_chan_decoder_chk.sv
module ide_chan_decoder_chk #(
  parameter int N_CH  = 2,
  parameter int OFF_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       prog_if,
  input logic             req_valid,
  input logic [N_CH-1:0]  cmd_stb,
  input logic [N_CH-1:0]  ctl_stb,
  input logic [OFF_W-1:0] stb_off,
  input logic [1:0]       stb_size,
  input logic             fill_vld,
  input logic [31:0]      fill_data,
  input logic [7:0]       irq_pin
);
  logic seen_q = 1'b0;
  always_ff @(posedge clk) seen_q <= 1'b1;

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_stb, ctl_stb}));

  assert_strobe_from_req_R10: assert property (@(posedge clk) disable iff (rst)
    (seen_q && |{cmd_stb, ctl_stb}) |-> $past(req_valid));

  assert_ctl_byte_off2_R6: assert property (@(posedge clk) disable iff (rst)
    (|ctl_stb) |-> (stb_size == 2'd0 && stb_off == OFF_W'(2)));

  assert_wide_at_data_port_R8: assert property (@(posedge clk) disable iff (rst)
    ((|cmd_stb) && stb_size != 2'd0) |-> (stb_off == '0));

  assert_fill_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    fill_vld |-> !(|{cmd_stb, ctl_stb}));

  assert_fill_width_R9: assert property (@(posedge clk) disable iff (rst)
    fill_vld |-> (fill_data == 32'h0000_00FF || fill_data == 32'h0000_FFFF ||
                  fill_data == 32'hFFFF_FFFF));

  assert_pin_values_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_pin == 8'd0 || irq_pin == 8'd1));

  assert_compat_select_R2: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !$past(rst) && $past(prog_if[3:0]) == 4'hA) |-> irq_pin == 8'd0);

  assert_native_select_R2: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !$past(rst) && $past(prog_if[3:0]) == 4'hF) |-> irq_pin == 8'd1);
endmodule

bind ide_chan_decoder ide_chan_decoder_chk #(.N_CH(N_CH), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .prog_if(prog_if), .req_valid(req_valid),
  .cmd_stb(cmd_stb), .ctl_stb(ctl_stb), .stb_off(stb_off),
  .stb_size(stb_size), .fill_vld(fill_vld), .fill_data(fill_data),
  .irq_pin(irq_pin)
);

// File: tb/ide_chan_decoder_bench.sv
`timescale 1ns/1ps
module ide_chan_decoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  prog_if;
  logic [31:0] nat_cmd_base, nat_ctl_base;
  logic        req_valid, req_wr;
  logic [15:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic [1:0]  cmd_stb, ctl_stb;
  logic        stb_wr, fill_vld;
  logic [2:0]  stb_off;
  logic [1:0]  stb_size;
  logic [31:0] stb_wdata, fill_data;
  logic [7:0]  irq_pin;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit m_compat = 0;

  always #2 clk = ~clk;

  ide_chan_decoder u_ide_chan_decoder (
    .clk(clk), .rst(rst), .prog_if(prog_if),
    .nat_cmd_base(nat_cmd_base), .nat_ctl_base(nat_ctl_base),
    .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .cmd_stb(cmd_stb), .ctl_stb(ctl_stb), .stb_wr(stb_wr),
    .stb_off(stb_off), .stb_size(stb_size), .stb_wdata(stb_wdata),
    .fill_vld(fill_vld), .fill_data(fill_data), .irq_pin(irq_pin)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected outcome from the requirements (R4..R9, R11).
  function automatic void model(input bit compat, input logic [15:0] a,
      input logic [1:0] sz, input bit wr,
      output logic [1:0] ecmd, output logic [1:0] ectl,
      output logic [2:0] eoff, output bit efill, output logic [31:0] efd);
    logic [15:0] cb, kb;
    bit found, ok;
    ecmd = 0; ectl = 0; eoff = 0; found = 0; ok = 0;
    for (int c = 0; c < 2; c++) begin
      cb = compat ? (c == 0 ? 16'h01F0 : 16'h0170) : nat_cmd_base[c*16 +: 16];
      kb = compat ? (c == 0 ? 16'h03F4 : 16'h0374) : nat_ctl_base[c*16 +: 16];
      if (!found && a[15:3] == cb[15:3]) begin
        found = 1; eoff = a[2:0]; ok = (sz == 0) || (a[2:0] == 0);
        if (ok) ecmd[c] = 1'b1;
      end
      if (!found && a[15:2] == kb[15:2]) begin
        found = 1; eoff = {1'b0, a[1:0]}; ok = (sz == 0) && (a[1:0] == 2);
        if (ok) ectl[c] = 1'b1;
      end
    end
    efill = !wr && !ok;
    efd = !efill ? 32'h0 : (sz == 0 ? 32'h0000_00FF :
                            sz == 1 ? 32'h0000_FFFF : 32'hFFFF_FFFF);
  endfunction

  task automatic access(input logic [15:0] a, input logic [1:0] sz,
                        input bit wr, input logic [31:0] wd, input string req);
    logic [1:0] ecmd, ectl; logic [2:0] eoff; bit efill; logic [31:0] efd;
    model(m_compat, a, sz, wr, ecmd, ectl, eoff, efill, efd);
    req_valid = 1; req_addr = a; req_size = sz; req_wr = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(cmd_stb == ecmd, req, "cmd_stb", 32'(cmd_stb), 32'(ecmd));
    chk(ctl_stb == ectl, req, "ctl_stb", 32'(ctl_stb), 32'(ectl));
    chk(fill_vld == efill, req, "fill_vld", 32'(fill_vld), 32'(efill));
    if (efill) chk(fill_data == efd, req, "fill_data", fill_data, efd);
    if (|{ecmd, ectl}) begin
      chk(stb_off == eoff, req, "stb_off", 32'(stb_off), 32'(eoff));
      chk(stb_wr == wr && stb_size == sz, req, "stb_wr/size",
          32'({stb_wr, stb_size}), 32'({wr, sz}));
      chk(stb_wdata == wd, req, "stb_wdata", stb_wdata, wd);
    end
  endtask

  task automatic set_mode(input logic [7:0] v);
    prog_if = v;
    if (v[3:0] == 4'hA) m_compat = 1;
    else if (v[3:0] == 4'hF) m_compat = 0;
    @(negedge clk);
    chk(irq_pin == (m_compat ? 8'd0 : 8'd1), "R3", "irq_pin",
        32'(irq_pin), m_compat ? 32'd0 : 32'd1);
  endtask

  function automatic logic [15:0] pick_addr(input int r);
    case (r % 9)
      0: return 16'h01F0 + 16'(r[6:4]);
      1: return 16'h03F4 + 16'(r[5:4]);
      2: return 16'h0170 + 16'(r[6:4]);
      3: return 16'h0374 + 16'(r[5:4]);
      4: return nat_cmd_base[15:0]  + 16'(r[6:4]);
      5: return nat_ctl_base[15:0]  + 16'(r[5:4]);
      6: return nat_cmd_base[31:16] + 16'(r[6:4]);
      7: return nat_ctl_base[31:16] + 16'(r[5:4]);
      default: return 16'(r >> 8);
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst = 1; prog_if = 8'h00; req_valid = 0; req_wr = 0; req_addr = 0;
    req_size = 0; req_wdata = 0;
    nat_cmd_base = {16'hC010, 16'hC000};
    nat_ctl_base = {16'hC01C, 16'hC008};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(cmd_stb == 0 && ctl_stb == 0, "R1", "strobes", 32'({cmd_stb, ctl_stb}), 0);
    chk(fill_vld == 0, "R1", "fill_vld", 32'(fill_vld), 0);
    chk(irq_pin == 8'd1, "R1", "irq_pin", 32'(irq_pin), 1);

    // R5: native windows; R7 byte at any offset
    access(16'hC003, 0, 0, 0, "R7");
    access(16'hC00A, 0, 1, 32'h5A, "R6");
    access(16'hC014, 0, 1, 32'h11, "R5");
    access(16'hC005, 0, 0, 0, "R5");          // low base bits ignored
    access(16'h01F0, 0, 0, 0, "R5");          // compat address unused in native
    // R8 wide accesses
    access(16'hC000, 1, 0, 0, "R8");
    access(16'hC010, 2, 1, 32'hDEADBEEF, "R8");
    access(16'hC002, 1, 0, 0, "R8");
    access(16'hC012, 3, 1, 32'h1234, "R8");
    // R6 control filter
    access(16'hC009, 0, 0, 0, "R6");
    access(16'hC00A, 1, 0, 0, "R6");
    access(16'hC01E, 2, 1, 32'h77, "R6");
    access(16'hC01E, 0, 0, 0, "R6");
    // R9 no window
    access(16'h8000, 2, 0, 0, "R9");
    access(16'h8000, 0, 1, 32'h1, "R9");
    // R10 pulse falls after one cycle
    access(16'hC000, 0, 1, 32'h3, "R10");
    @(negedge clk);
    chk(cmd_stb == 0 && fill_vld == 0, "R10", "pulse width",
        32'({cmd_stb, fill_vld}), 0);

    // R2 mode control
    set_mode(8'h07);
    set_mode(8'h3A);
    access(16'h03F6, 0, 0, 0, "R4");
    access(16'h0376, 0, 1, 32'h42, "R4");
    access(16'h0177, 0, 0, 0, "R4");
    access(16'h01F0, 2, 0, 0, "R4");
    access(16'hC000, 0, 0, 0, "R4");          // native base ignored in compat
    access(16'h03F5, 0, 0, 0, "R6");
    set_mode(8'h00);
    access(16'h0170, 0, 0, 0, "R2");          // mode held
    set_mode(8'hCF);
    access(16'h0170, 0, 0, 0, "R2");

    // R11 overlap priority
    nat_cmd_base = {16'hC000, 16'hC000};
    nat_ctl_base = {16'hC004, 16'hC004};
    access(16'hC001, 0, 0, 0, "R11");
    access(16'hC006, 0, 0, 0, "R11");
    nat_cmd_base = {16'hC000, 16'hD000};
    access(16'hC006, 0, 1, 32'h9, "R11");
    nat_cmd_base = {16'hC010, 16'hC000};
    nat_ctl_base = {16'hC01C, 16'hC008};

    // Seeded random mix
    void'($urandom(32'h1DEC0DE));
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom);
      if (r[31:27] == 0) set_mode($urandom % 2 ? 8'h0A : 8'h0F);
      access(pick_addr(r), 2'($urandom), bit'($urandom), $urandom, "R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule